// File: doc/BRIEF.md
# Ring-oscillator pair response generator

This block turns one pair of free-running ring oscillators into a single response bit. Each oscillator clocks its own divide-by-two flip-flop. The divided signal is brought into the system clock domain and its rising edges are counted. Counting runs only during an evaluation window. The window length is given in system clock cycles, so it can be set from a few cycles up to millions of cycles. When the window closes, the two counts are compared. The larger count decides the bit, and a one-cycle done pulse marks the result.

Every response bit has its own two oscillators. A device that needs many bits uses one instance of this block per bit, so no oscillator ever feeds two bits. The block does not model the oscillators or report the results to a host. It does not control where the oscillators are placed.

Results leave on plain status pins, not on a stream. The block has no back-pressure. The counts, the bit and the flags stay stable from the done pulse until the next accepted start, and the consumer may read them at any time in that interval.

Top module: `osc_pair_puf`

## Requirements
- R1: Each counter advances once per rising edge of its divided oscillator, which is one count per two oscillator rising edges. The divider state is cleared only by reset and carries over from one measurement to the next.
- R2: An accepted start with window length W counts edges during the W clock cycles that follow the start edge. done_o is high in the cycle W+1 clock edges after the start edge. With W = 0, nothing is counted and done_o follows after one edge.
- R3: An accepted start clears both counts, resp_bit_o, tie_o and overflow_o at the start edge.
- R4: At done_o, resp_bit_o is 1 exactly when cnt_a_o is greater than cnt_b_o.
- R5: When the two counts are equal, resp_bit_o is 0 and tie_o is 1. Otherwise tie_o is 0.
- R6: done_o is high for exactly one cycle. After it, the counts, resp_bit_o and tie_o hold until the next accepted start.
- R7: A counter stops at 2^CNT_W-1. An edge that arrives while a counter is at that value sets overflow_o.
- R8: A start strobe that arrives while a measurement is running is ignored. The window is not restarted and the counts are not cleared.
- R9: After reset, every output is 0.
- R10: Oscillator edges outside the window leave the counts unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, also clears both dividers |
| start_i | input | 1 | Start strobe; accepted only when idle |
| win_len_i | input | WIN_W | Evaluation window length in clock cycles |
| osc_a_i | input | 1 | Oscillator A output |
| osc_b_i | input | 1 | Oscillator B output |
| resp_bit_o | output | 1 | Response bit, 1 when count A exceeds count B |
| tie_o | output | 1 | Counts were equal at comparison |
| overflow_o | output | 1 | A counter lost an edge at saturation |
| cnt_a_o | output | CNT_W | Edge count of oscillator A |
| cnt_b_o | output | CNT_W | Edge count of oscillator B |
| done_o | output | 1 | One-cycle pulse when the result is valid |

## Verification
The bench builds the block with CNT_W = 6 and WIN_W = 12. With a 6-bit counter, saturation at 63 and the lost-edge flag can be reached in a few hundred cycles. The 12-bit window still allows windows of several hundred cycles. The oscillators are driven as slow pulse trains aligned to the falling clock edge and kept well inside each window, so the expected counts are exact. Those counts follow from the divider parity that the bench tracks from one measurement to the next.

// File: rtl/ropuf_pkg.sv
`timescale 1ns/1ps
package ropuf_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_CMP  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/osc_toggle_sync.sv
`timescale 1ns/1ps
// Divide-by-two of a free-running oscillator, resynchronised, with rise detect.
module osc_toggle_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_i,
  output logic rise_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic             tgl_q;
  logic [TOP:0]     sync_q;
  logic             last_q;

  // Divider lives in the oscillator domain; only reset clears it.
  always_ff @(posedge osc_i or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= ~tgl_q;
  end

  // Synchroniser chain: stage 0 samples the divider, later stages follow.
  genvar s;
  generate
    for (s = 0; s <= TOP; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= tgl_q;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[TOP];
  end

  assign rise_o = sync_q[TOP] & ~last_q;

  // A detected rise must be followed by a low level first (R1).
  assert_rise_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sat_edge_counter.sv
`timescale 1ns/1ps
// Saturating edge counter with a lost-edge flag.
module sat_edge_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
      sat_o <= 1'b0;
    end else if (clr_i) begin
      cnt_o <= '0;
      sat_o <= 1'b0;
    end else if (en_i && inc_i) begin
      if (cnt_o == CNT_MAX) sat_o <= 1'b1;
      else                  cnt_o <= cnt_o + 1'b1;
    end
  end

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == CNT_MAX) && !clr_i |=> cnt_o == CNT_MAX);

  assert_step_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1));

  assert_still_outside_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i && !en_i |=> $stable(cnt_o) && $stable(sat_o));
endmodule

// File: rtl/window_sequencer.sv
`timescale 1ns/1ps
// Evaluation window timer: idle -> run for W cycles -> compare -> idle.
module window_sequencer
  import ropuf_pkg::*;
#(
  parameter int WIN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             clr_o,
  output logic             run_o,
  output logic             cmp_o
);
  seq_state_e       state_q;
  logic [WIN_W-1:0] timer_q;

  assign clr_o = (state_q == SEQ_IDLE) && start_i;
  assign run_o = (state_q == SEQ_RUN);
  assign cmp_o = (state_q == SEQ_CMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      timer_q <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          timer_q <= win_len_i;
          state_q <= (win_len_i == '0) ? SEQ_CMP : SEQ_RUN;
        end
        SEQ_RUN: begin
          timer_q <= timer_q - 1'b1;
          if (timer_q <= {{(WIN_W-1){1'b0}}, 1'b1}) state_q <= SEQ_CMP;
        end
        SEQ_CMP: state_q <= SEQ_IDLE;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assert_window_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o && (win_len_i != '0) |=> run_o && (timer_q == $past(win_len_i)));

  assert_zero_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o && (win_len_i == '0) |=> cmp_o);

  assert_no_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_o && (timer_q > 1) |=> run_o && (timer_q == $past(timer_q) - 1'b1));

  assert_cmp_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_o |=> !cmp_o && !run_o);
endmodule

// File: rtl/osc_pair_puf.sv
`timescale 1ns/1ps
// One response bit from two dedicated oscillators.
module osc_pair_puf #(
  parameter int CNT_W       = 24,
  parameter int WIN_W       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIN_W-1:0] win_len_i,
  input  logic             osc_a_i,
  input  logic             osc_b_i,
  output logic             resp_bit_o,
  output logic             tie_o,
  output logic             overflow_o,
  output logic [CNT_W-1:0] cnt_a_o,
  output logic [CNT_W-1:0] cnt_b_o,
  output logic             done_o
);
  localparam int LANES = 2;

  logic [LANES-1:0] osc_vec;
  logic [LANES-1:0] rise;
  logic [LANES-1:0] sat;
  logic [CNT_W-1:0] cnt_arr [LANES];
  logic             seq_clr, seq_run, seq_cmp;

  assign osc_vec = {osc_b_i, osc_a_i};

  window_sequencer #(.WIN_W(WIN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .win_len_i (win_len_i),
    .clr_o     (seq_clr),
    .run_o     (seq_run),
    .cmp_o     (seq_cmp)
  );

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_lane
      osc_toggle_sync #(.SYNC_STAGES(SYNC_STAGES)) u_tap (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_i  (osc_vec[i]),
        .rise_o (rise[i])
      );
      sat_edge_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (seq_clr),
        .en_i  (seq_run),
        .inc_i (rise[i]),
        .cnt_o (cnt_arr[i]),
        .sat_o (sat[i])
      );
    end
  endgenerate

  assign cnt_a_o    = cnt_arr[0];
  assign cnt_b_o    = cnt_arr[1];
  assign overflow_o = |sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_bit_o <= 1'b0;
      tie_o      <= 1'b0;
      done_o     <= 1'b0;
    end else if (seq_clr) begin
      resp_bit_o <= 1'b0;
      tie_o      <= 1'b0;
      done_o     <= 1'b0;
    end else if (seq_cmp) begin
      resp_bit_o <= (cnt_arr[0] > cnt_arr[1]);
      tie_o      <= (cnt_arr[0] == cnt_arr[1]);
      done_o     <= 1'b1;
    end else begin
      done_o     <= 1'b0;
    end
  end

  assert_bit_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> resp_bit_o == (cnt_a_o > cnt_b_o));

  assert_tie_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (tie_o == (cnt_a_o == cnt_b_o)) && !(tie_o && resp_bit_o));

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> !done_o && $stable(resp_bit_o) && $stable(tie_o)
                           && $stable(cnt_a_o) && $stable(cnt_b_o));

  assert_start_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_clr |=> (cnt_a_o == '0) && (cnt_b_o == '0) && !overflow_o
                && !resp_bit_o && !tie_o);
endmodule

// File: tb/sim_osc_pair_puf.sv
`timescale 1ns/1ps
module sim_osc_pair_puf;
  localparam int CNT_W = 6;
  localparam int WIN_W = 12;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [WIN_W-1:0] win_len_i = '0;
  logic             osc_a_i = 1'b0;
  logic             osc_b_i = 1'b0;
  logic             resp_bit_o, tie_o, overflow_o, done_o;
  logic [CNT_W-1:0] cnt_a_o, cnt_b_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  tgl_a = 1'b0;
  bit  tgl_b = 1'b0;
  int  last_k;

  always #10 clk = ~clk;

  osc_pair_puf #(.CNT_W(CNT_W), .WIN_W(WIN_W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .win_len_i(win_len_i),
    .osc_a_i(osc_a_i), .osc_b_i(osc_b_i), .resp_bit_o(resp_bit_o),
    .tie_o(tie_o), .overflow_o(overflow_o), .cnt_a_o(cnt_a_o),
    .cnt_b_o(cnt_b_o), .done_o(done_o)
  );

  // Rising edges of the divided signal produced by n oscillator rises.
  function automatic int exp_rises(int n, bit t0);
    return (n + (t0 ? 0 : 1)) / 2;
  endfunction

  function automatic int clip(int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive_osc(int sel, int n, int p);
    repeat (2) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (sel == 0) osc_a_i = 1'b1; else osc_b_i = 1'b1;
      @(negedge clk);
      if (sel == 0) osc_a_i = 1'b0; else osc_b_i = 1'b0;
      repeat (p - 1) @(negedge clk);
    end
  endtask

  // One measurement, checked against values derived from the requirements.
  task automatic measure(int na, int pa, int nb, int pb, int w, bit poke, string tag);
    int ea, eb, k;
    bit ov;
    ea = exp_rises(na, tgl_a);
    eb = exp_rises(nb, tgl_b);
    ov = (ea > CMAX) || (eb > CMAX);
    ea = clip(ea);
    eb = clip(eb);
    @(negedge clk);
    start_i = 1'b1;
    win_len_i = WIN_W'(w);
    @(negedge clk);
    start_i = 1'b0;
    k = 0;
    fork
      drive_osc(0, na, pa);
      drive_osc(1, nb, pb);
      begin
        while (!done_o && k < 6000) begin
          @(negedge clk);
          k++;
          start_i = (poke && k == w / 2);
        end
        start_i = 1'b0;
      end
    join
    last_k = k;
    tgl_a ^= na[0];
    tgl_b ^= nb[0];
    check(k == w + 1, "R2", {tag, " done delay"}, k, w + 1);
    check(cnt_a_o == ea, "R1", {tag, " count A"}, cnt_a_o, ea);
    check(cnt_b_o == eb, "R1", {tag, " count B"}, cnt_b_o, eb);
    check(resp_bit_o == (ea > eb), "R4", {tag, " response"}, resp_bit_o, ea > eb);
    check(tie_o == (ea == eb), "R5", {tag, " tie"}, tie_o, ea == eb);
    check(overflow_o == ov, "R7", {tag, " overflow"}, overflow_o, ov);
  endtask

  initial begin : watchdog
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int na, nb, pa, pb, w, m;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(!done_o && !resp_bit_o && !tie_o && !overflow_o, "R9", "flags after reset",
          {done_o, resp_bit_o, tie_o, overflow_o}, 0);
    check(cnt_a_o == 0 && cnt_b_o == 0, "R9", "counts after reset", cnt_a_o + cnt_b_o, 0);

    // R2: zero-length window gives zero counts and a tie
    measure(0, 2, 0, 2, 0, 1'b0, "zero window");

    // R5: equal counts
    measure(10, 3, 10, 2, 40, 1'b0, "equal");

    // Directed: A wins, then B wins
    measure(30, 2, 12, 4, 70, 1'b0, "A larger");
    measure(7, 5, 25, 3, 90, 1'b0, "B larger");

    // R6: done is one cycle; R10: edges after the window are not counted
    begin
      int ca, cr;
      ca = cnt_a_o;
      cr = resp_bit_o;
      @(negedge clk);
      check(!done_o, "R6", "done width", done_o, 0);
      drive_osc(0, 6, 3);
      tgl_a ^= 1'b0;
      repeat (4) @(negedge clk);
      check(cnt_a_o == ca, "R10", "count after window", cnt_a_o, ca);
      check(resp_bit_o == cr, "R6", "response held", resp_bit_o, cr);
    end

    // R8: a second start mid-window neither restarts nor clears
    measure(20, 3, 9, 3, 80, 1'b1, "mid start");

    // R7: saturation of counter A
    measure(140, 2, 20, 2, 300, 1'b0, "saturate");
    check(cnt_a_o == CMAX, "R7", "saturated value", cnt_a_o, CMAX);

    // R3: a new start clears counts, flags and response
    @(negedge clk);
    start_i = 1'b1;
    win_len_i = WIN_W'(50);
    @(negedge clk);
    start_i = 1'b0;
    check(cnt_a_o == 0 && cnt_b_o == 0, "R3", "counts cleared", cnt_a_o + cnt_b_o, 0);
    check(!overflow_o && !resp_bit_o && !tie_o, "R3", "flags cleared",
          {overflow_o, resp_bit_o, tie_o}, 0);
    m = 0;
    while (!done_o && m < 100) begin
      @(negedge clk);
      m++;
    end

    // Constrained random measurements
    for (int t = 0; t < 16; t++) begin
      na = $urandom_range(0, 40);
      nb = $urandom_range(0, 40);
      pa = $urandom_range(2, 5);
      pb = $urandom_range(2, 5);
      w  = ((na * pa > nb * pb) ? na * pa : nb * pb) + 8 + $urandom_range(0, 20);
      measure(na, pa, nb, pb, w, 1'b0, "random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule